// File: doc/BRIEF.md
# Radix-4 Fat-Tree Router With Two Uplinks

This block is one routing node of a tree-shaped on-chip network. Each node has four child links facing down the tree and two parent links facing up, and every link is a full-duplex valid/ready channel. A packet is a single flit made of a destination address and a payload. A packet from a child either climbs toward the root or turns here and goes down to another child. A packet from a parent always goes down. The parameters `LEVEL` and `POS` give the node's height in the tree and its place within that level. From these, the node decides whether a destination lies inside its own subtree.

Each child input has one fixed parent link for climbing traffic, so all packets from one source to one destination follow the same path and arrive in order. When a packet descends, two address bits pick the child. Each of the six outputs has its own round-robin arbiter and one output register. When an input loses arbitration, its packet moves into a one-entry shadow register, and the input drops its ready until that packet has left.

Top module: `qft_router`

## Requirements
- R1: A flit from child input i whose address bits above this level's pair (bits [ADDR_W-1:2*LEVEL+2]) differ from `POS` leaves on parent output i/2: children 0 and 1 climb on parent 0, and children 2 and 3 climb on parent 1.
- R2: A flit from a child input whose upper address bits equal `POS` leaves on child output number addr[2*LEVEL+1:2*LEVEL], provided that number differs from its own input.
- R3: A flit from either parent input always leaves on child output number addr[2*LEVEL+1:2*LEVEL].
- R4: A flit from child input i that would descend to child output i is accepted and discarded. It appears on no output and does not drop that input's ready.
- R5: A flit accepted at a clock edge while its output register is free shows up as valid on that output right after the same edge.
- R6: While an output is valid and its ready is low, the output stays valid and its data does not change.
- R7: When inputs compete for one output, grants rotate round-robin from the last winner. After reset, the candidate in the lowest slot has the highest priority. For a parent output, slot 0 is the lower child. For a child output, the other children come first in ascending order, then parent 0, then parent 1.
- R8: An accepted flit that loses arbitration is held in its input's shadow register. That input's ready is low from the next cycle until the held flit is granted.
- R9: Every accepted flit that is not discarded is delivered exactly once. Flits from one input to one output leave in the order they entered.
- R10: After reset, every input is ready and no output is valid.

Flit layout: the address occupies bits [ADDR_W+PAY_W-1:PAY_W] and the payload bits [PAY_W-1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dn_in_valid | input | 4 | Child input valid, one bit per child |
| dn_in_data | input | 4*(ADDR_W+PAY_W) | Child input flits, child k at slice k |
| dn_in_ready | output | 4 | Child input ready (low while its shadow register is full) |
| dn_out_valid | output | 4 | Child output valid |
| dn_out_data | output | 4*(ADDR_W+PAY_W) | Child output flits |
| dn_out_ready | input | 4 | Child output ready from below |
| up_in_valid | input | 2 | Parent input valid |
| up_in_data | input | 2*(ADDR_W+PAY_W) | Parent input flits |
| up_in_ready | output | 2 | Parent input ready |
| up_out_valid | output | 2 | Parent output valid |
| up_out_data | output | 2*(ADDR_W+PAY_W) | Parent output flits |
| up_out_ready | input | 2 | Parent output ready from above |

## Verification
A wrong route decode, such as a bad turn decision or a swapped child number, puts a flit on the wrong port one cycle after it is accepted. The check that every output's address matches that output catches this right away. A corrupt shadow or arbiter state, for example a flag stuck full or a lost grant, shows up as a missing, duplicated or out-of-order flit. It also shows up as a ready that stays low. The per-source queues expose these within a few cycles of the contention, or at the final drain at the latest. A wrong arbiter pointer breaks the strict alternation that the directed contention case expects on parent 0.

// File: rtl/qft_pkg.sv
// Shared port numbering for the radix-4 fat-tree router.
// Ports 0..3 are children, ports 4..5 are parents.
package qft_pkg;
    localparam int NUM_DN = 4;
    localparam int NUM_UP = 2;
    localparam int NUM_PORTS = NUM_DN + NUM_UP;

    // Number of candidate inputs feeding output o.
    function automatic int cand_count(int o);
        return (o < NUM_DN) ? (NUM_PORTS - 1) : 2;
    endfunction

    // Input port feeding slot s of the mux for output o.
    function automatic int src_of(int o, int s);
        if (o < NUM_DN) begin
            if (s >= NUM_DN - 1) return s + 1;
            return (s < o) ? s : s + 1;
        end
        return 2 * (o - NUM_DN) + s;
    endfunction

    // Fixed parent output for child input i.
    function automatic int uplink_of(int i);
        return NUM_DN + i / 2;
    endfunction
endpackage

// File: rtl/qft_rr_arb.sv
// Round-robin arbiter over N requests.
// Assumes requests are already qualified by the caller. The pointer moves
// only on a grant, and after reset slot 0 has the highest priority.
module qft_rr_arb #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] last_q;
    logic [PW-1:0] win;

    // Search from the slot after the last winner for the first request.
    always_comb begin
        int idx;
        gnt = '0;
        win = last_q;
        for (int off = 1; off <= N; off++) begin
            idx = (int'(last_q) + off) % N;
            if (req[idx] && (gnt == '0)) begin
                gnt[idx] = 1'b1;
                win      = PW'(idx);
            end
        end
    end

    // Remember the winner so it has the lowest priority next time.
    always_ff @(posedge clk) begin
        if (!rst_n)      last_q <= PW'(N - 1);
        else if (|gnt)   last_q <= win;
    end
endmodule

// File: rtl/qft_in_stage.sv
// Input stage for one router port: a one-entry shadow register and the route decode.
// Assumes the upstream sender holds the flit while ready is low. The head is
// the shadow entry when it is full and the live input otherwise.
module qft_in_stage
    import qft_pkg::*;
#(
    parameter int       ADDR_W = 6,
    parameter int       PAY_W  = 16,
    parameter int       LEVEL  = 1,
    parameter int       POS    = 0,
    parameter int       PORT   = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [ADDR_W+PAY_W-1:0]   in_data,
    output logic                      in_ready,
    input  logic                      taken,
    output logic                      head_valid,
    output logic [ADDR_W+PAY_W-1:0]   head_data,
    output logic [NUM_PORTS-1:0]      dest
);
    localparam int FW      = ADDR_W + PAY_W;
    localparam int CHILD_LO = PAY_W + 2 * LEVEL;
    localparam int UPPER_LO = CHILD_LO + 2;
    localparam bit HAS_UP   = (UPPER_LO < FW);

    logic            full_q;
    logic [FW-1:0]   shadow_q;
    logic [1:0]      child;
    logic            here;
    logic            drop;

    assign in_ready   = !full_q;
    assign head_valid = full_q | in_valid;
    assign head_data  = full_q ? shadow_q : in_data;
    assign child      = head_data[CHILD_LO +: 2];

    // Decide whether the destination lies in this node's subtree.
    generate
        if (HAS_UP) begin : g_upper
            localparam int UW = FW - UPPER_LO;
            assign here = (head_data[FW-1:UPPER_LO] == UW'(POS));
        end else begin : g_root
            assign here = 1'b1;
        end
    endgenerate

    // Map the head flit to a one-hot output request.
    always_comb begin
        dest = '0;
        drop = 1'b0;
        if (PORT >= NUM_DN) begin
            dest[child] = 1'b1;
        end else if (!here) begin
            dest[uplink_of(PORT)] = 1'b1;
        end else if (int'(child) == PORT) begin
            drop = 1'b1;
        end else begin
            dest[child] = 1'b1;
        end
    end

    // Park a live flit that lost arbitration; release it once granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
        end else if (full_q) begin
            if (taken) full_q <= 1'b0;
        end else if (in_valid && !taken && !drop) begin
            full_q   <= 1'b1;
            shadow_q <= in_data;
        end
    end
endmodule

// File: rtl/qft_out_stage.sv
// Output stage: an N:1 round-robin mux feeding a single output register.
// Assumes the candidate requests and data are already selected for this
// output. A grant is issued only when the register can take a new flit.
module qft_out_stage #(
    parameter int FW = 22,
    parameter int N  = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    cand_req,
    input  logic [N*FW-1:0] cand_data,
    output logic [N-1:0]    cand_gnt,
    input  logic            out_ready,
    output logic            out_valid,
    output logic [FW-1:0]   out_data
);
    logic          load_ok;
    logic [N-1:0]  qual_req;
    logic [FW-1:0] sel_data;

    assign load_ok  = !out_valid || out_ready;
    assign qual_req = cand_req & {N{load_ok}};

    qft_rr_arb #(.N(N)) arb_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (qual_req),
        .gnt   (cand_gnt)
    );

    // Select the granted candidate's flit.
    always_comb begin
        sel_data = '0;
        for (int s = 0; s < N; s++) begin
            if (cand_gnt[s]) sel_data = cand_data[s*FW +: FW];
        end
    end

    // Load the output register when it is free or being drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load_ok) begin
            out_valid <= |cand_gnt;
            if (|cand_gnt) out_data <= sel_data;
        end
    end
endmodule

// File: rtl/qft_router.sv
// Radix-4 fat-tree router with four child links and two parent links.
// Assumes single-flit packets and valid/ready links on which a transfer
// happens when both are high at a rising edge. LEVEL selects the address
// pair decoded here; POS is this node's value of the address bits above it.
module qft_router
    import qft_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int PAY_W  = 16,
    parameter int LEVEL  = 1,
    parameter int POS    = 0
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [3:0]                         dn_in_valid,
    input  logic [4*(ADDR_W+PAY_W)-1:0]        dn_in_data,
    output logic [3:0]                         dn_in_ready,
    output logic [3:0]                         dn_out_valid,
    output logic [4*(ADDR_W+PAY_W)-1:0]        dn_out_data,
    input  logic [3:0]                         dn_out_ready,
    input  logic [1:0]                         up_in_valid,
    input  logic [2*(ADDR_W+PAY_W)-1:0]        up_in_data,
    output logic [1:0]                         up_in_ready,
    output logic [1:0]                         up_out_valid,
    output logic [2*(ADDR_W+PAY_W)-1:0]        up_out_data,
    input  logic [1:0]                         up_out_ready
);
    localparam int FW   = ADDR_W + PAY_W;
    localparam int MAXC = NUM_PORTS - 1;

    logic [NUM_PORTS-1:0]       in_v;
    logic [NUM_PORTS-1:0]       in_r;
    logic [FW-1:0]              in_d  [NUM_PORTS];
    logic [NUM_PORTS-1:0]       hv;
    logic [FW-1:0]              hd    [NUM_PORTS];
    logic [NUM_PORTS-1:0]       dest  [NUM_PORTS];
    logic [NUM_PORTS-1:0]       taken;
    logic [MAXC-1:0]            gnt_all [NUM_PORTS];
    logic [NUM_PORTS-1:0]       ov;
    logic [NUM_PORTS-1:0]       ordy;
    logic [FW-1:0]              od    [NUM_PORTS];

    assign in_v = {up_in_valid, dn_in_valid};
    assign ordy = {up_out_ready, dn_out_ready};
    assign dn_in_ready  = in_r[NUM_DN-1:0];
    assign up_in_ready  = in_r[NUM_PORTS-1:NUM_DN];
    assign dn_out_valid = ov[NUM_DN-1:0];
    assign up_out_valid = ov[NUM_PORTS-1:NUM_DN];

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            if (p < NUM_DN) begin : g_dn
                assign in_d[p] = dn_in_data[p*FW +: FW];
                assign dn_out_data[p*FW +: FW] = od[p];
            end else begin : g_up
                assign in_d[p] = up_in_data[(p-NUM_DN)*FW +: FW];
                assign up_out_data[(p-NUM_DN)*FW +: FW] = od[p];
            end

            qft_in_stage #(
                .ADDR_W (ADDR_W), .PAY_W (PAY_W),
                .LEVEL  (LEVEL),  .POS   (POS), .PORT (p)
            ) in_i (
                .clk        (clk),
                .rst_n      (rst_n),
                .in_valid   (in_v[p]),
                .in_data    (in_d[p]),
                .in_ready   (in_r[p]),
                .taken      (taken[p]),
                .head_valid (hv[p]),
                .head_data  (hd[p]),
                .dest       (dest[p])
            );
        end

        for (genvar o = 0; o < NUM_PORTS; o++) begin : g_out
            localparam int NC = cand_count(o);
            logic [NC-1:0]    creq;
            logic [NC*FW-1:0] cdat;
            logic [NC-1:0]    cgnt;

            for (genvar s = 0; s < NC; s++) begin : g_slot
                assign creq[s]          = hv[src_of(o, s)] & dest[src_of(o, s)][o];
                assign cdat[s*FW +: FW] = hd[src_of(o, s)];
                assign gnt_all[o][s]    = cgnt[s];
            end
            for (genvar s = NC; s < MAXC; s++) begin : g_pad
                assign gnt_all[o][s] = 1'b0;
            end

            qft_out_stage #(.FW(FW), .N(NC)) out_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .cand_req  (creq),
                .cand_data (cdat),
                .cand_gnt  (cgnt),
                .out_ready (ordy[o]),
                .out_valid (ov[o]),
                .out_data  (od[o])
            );
        end
    endgenerate

    // Fold all output grants back onto the inputs that won them.
    always_comb begin
        taken = '0;
        for (int o = 0; o < NUM_PORTS; o++) begin
            for (int s = 0; s < MAXC; s++) begin
                if (s < cand_count(o) && gnt_all[o][s]) taken[src_of(o, s)] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/qft_router_chk.sv
// Property checker for qft_router, attached with bind.
// Assumes the same parameters as the instance it observes.
module qft_router_chk #(
    parameter int ADDR_W = 6,
    parameter int PAY_W  = 16,
    parameter int LEVEL  = 1,
    parameter int POS    = 0
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [3:0]                  dn_in_valid,
    input logic [3:0]                  dn_in_ready,
    input logic [3:0]                  dn_out_valid,
    input logic [4*(ADDR_W+PAY_W)-1:0] dn_out_data,
    input logic [3:0]                  dn_out_ready,
    input logic [1:0]                  up_in_valid,
    input logic [1:0]                  up_in_ready,
    input logic [1:0]                  up_out_valid,
    input logic [2*(ADDR_W+PAY_W)-1:0] up_out_data,
    input logic [1:0]                  up_out_ready
);
    localparam int FW       = ADDR_W + PAY_W;
    localparam int CHILD_LO = PAY_W + 2 * LEVEL;
    localparam int UPPER_LO = CHILD_LO + 2;

    logic [5:0]    all_ov, all_or, all_iv, all_ir;
    logic [FW-1:0] all_od [6];

    assign all_ov = {up_out_valid, dn_out_valid};
    assign all_or = {up_out_ready, dn_out_ready};
    assign all_iv = {up_in_valid, dn_in_valid};
    assign all_ir = {up_in_ready, dn_in_ready};

    generate
        for (genvar p = 0; p < 6; p++) begin : g_p
            if (p < 4) begin : g_d
                assign all_od[p] = dn_out_data[p*FW +: FW];
                // R2 / R3: a flit on child output p carries child number p.
                assert_child_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
                    all_ov[p] |-> (int'(all_od[p][CHILD_LO +: 2]) == p));
            end else begin : g_u
                assign all_od[p] = up_out_data[(p-4)*FW +: FW];
                if (UPPER_LO < FW) begin : g_cl
                    // R1: a climbing flit has a destination outside this subtree.
                    assert_climb_R1: assert property (@(posedge clk) disable iff (!rst_n)
                        all_ov[p] |-> (all_od[p][FW-1:UPPER_LO] != (FW-UPPER_LO)'(POS)));
                end
            end

            // R6: a stalled output holds its flit.
            assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (all_ov[p] && !all_or[p]) |=> (all_ov[p] && $stable(all_od[p])));

            // R8: ready drops only after a flit was offered on that input.
            assert_shadow_R8: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(all_ir[p]) |-> $past(all_iv[p]));
        end
    endgenerate
endmodule

bind qft_router qft_router_chk #(
    .ADDR_W (ADDR_W), .PAY_W (PAY_W), .LEVEL (LEVEL), .POS (POS)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .dn_in_valid  (dn_in_valid),
    .dn_in_ready  (dn_in_ready),
    .dn_out_valid (dn_out_valid),
    .dn_out_data  (dn_out_data),
    .dn_out_ready (dn_out_ready),
    .up_in_valid  (up_in_valid),
    .up_in_ready  (up_in_ready),
    .up_out_valid (up_out_valid),
    .up_out_data  (up_out_data),
    .up_out_ready (up_out_ready)
);

// File: tb/qft_router_tb_top.sv
// Self-checking bench for qft_router: directed corner cases, then seeded random traffic.
module qft_router_tb_top;
    localparam int ADDR_W = 6;
    localparam int PAY_W  = 16;
    localparam int FW     = ADDR_W + PAY_W;
    localparam int LEVEL  = 1;
    localparam int POS    = 0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0]    dn_in_valid, dn_in_ready, dn_out_valid, dn_out_ready;
    logic [4*FW-1:0] dn_in_data, dn_out_data;
    logic [1:0]    up_in_valid, up_in_ready, up_out_valid, up_out_ready;
    logic [2*FW-1:0] up_in_data, up_out_data;

    always #4 clk = ~clk;

    qft_router #(.ADDR_W(ADDR_W), .PAY_W(PAY_W), .LEVEL(LEVEL), .POS(POS)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .dn_in_valid(dn_in_valid), .dn_in_data(dn_in_data), .dn_in_ready(dn_in_ready),
        .dn_out_valid(dn_out_valid), .dn_out_data(dn_out_data), .dn_out_ready(dn_out_ready),
        .up_in_valid(up_in_valid), .up_in_data(up_in_data), .up_in_ready(up_in_ready),
        .up_out_valid(up_out_valid), .up_out_data(up_out_data), .up_out_ready(up_out_ready)
    );

    logic [FW-1:0] pend [6][$];
    logic [FW-1:0] expq [6][6][$];
    int            u0_src [$];
    int            seqn [6];
    bit            orv [6];
    int            nrun = 0;
    int            nfail = 0;
    int            cyc = 0;

    // Expected output port from the routing rules; -1 means discarded (R4).
    function automatic int exp_port(int src, logic [ADDR_W-1:0] a);
        int child = int'(a[2*LEVEL +: 2]);
        int upper = int'(a[ADDR_W-1:2*LEVEL+2]);
        if (src >= 4) return child;
        if (upper != POS) return 4 + src / 2;
        if (child == src) return -1;
        return child;
    endfunction

    function automatic logic [FW-1:0] out_flit(int o);
        return (o < 4) ? dn_out_data[o*FW +: FW] : up_out_data[(o-4)*FW +: FW];
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        nrun++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send(int src, logic [ADDR_W-1:0] a);
        pend[src].push_back({a, 3'(src), 13'(seqn[src])});
        seqn[src]++;
    endtask

    // One clock: drive at the falling edge, then account for the coming rising edge.
    task automatic cycle();
        logic [5:0] iv;
        logic [5:0] ir;
        logic [5:0] ov;
        @(negedge clk);
        iv = '0;
        for (int p = 0; p < 6; p++) begin
            logic [FW-1:0] d;
            iv[p] = (pend[p].size() > 0);
            d = iv[p] ? pend[p][0] : '0;
            if (p < 4) dn_in_data[p*FW +: FW] = d;
            else       up_in_data[(p-4)*FW +: FW] = d;
        end
        dn_in_valid = iv[3:0];
        up_in_valid = iv[5:4];
        for (int p = 0; p < 4; p++) dn_out_ready[p] = orv[p];
        for (int p = 0; p < 2; p++) up_out_ready[p] = orv[p+4];
        #1;
        ir = {up_in_ready, dn_in_ready};
        ov = {up_out_valid, dn_out_valid};
        for (int p = 0; p < 6; p++) begin
            if (iv[p] && ir[p]) begin
                logic [FW-1:0] f = pend[p].pop_front();
                int ep = exp_port(p, f[FW-1:PAY_W]);
                if (ep >= 0) expq[p][ep].push_back(f);
            end
        end
        for (int o = 0; o < 6; o++) begin
            if (ov[o] && orv[o]) begin
                logic [FW-1:0] f = out_flit(o);
                int s = int'(f[PAY_W-1:PAY_W-3]);
                if (s > 5 || expq[s][o].size() == 0) begin
                    chk(1'b0, "R9", "unexpected flit", longint'(f), 0);
                end else begin
                    logic [FW-1:0] e = expq[s][o].pop_front();
                    chk(f == e, "R9", "delivered flit", longint'(f), longint'(e));
                end
                if (o == 4) u0_src.push_back(s);
            end
        end
    endtask

    function automatic int outstanding();
        int n = 0;
        for (int a = 0; a < 6; a++) begin
            n += pend[a].size();
            for (int b = 0; b < 6; b++) n += expq[a][b].size();
        end
        return n;
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
            $finish;
        end
    end

    initial begin
        logic [FW-1:0] held;
        void'($urandom(32'd20240611));
        dn_in_valid = '0; up_in_valid = '0; dn_in_data = '0; up_in_data = '0;
        dn_out_ready = '1; up_out_ready = '1;
        for (int p = 0; p < 6; p++) begin orv[p] = 1'b1; seqn[p] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset state
        chk({up_in_ready, dn_in_ready} == 6'h3F, "R10", "ready after reset", {up_in_ready, dn_in_ready}, 6'h3F);
        chk({up_out_valid, dn_out_valid} == 6'h00, "R10", "valid after reset", {up_out_valid, dn_out_valid}, 0);

        // R1 + R5: child 0 climbs on parent 0 right after acceptance
        send(0, 6'h10);
        cycle(); cycle();
        chk(up_out_valid == 2'b01, "R1", "child0 climb port", up_out_valid, 2'b01);
        chk(dn_out_valid == 4'b0000, "R5", "no child output", dn_out_valid, 0);
        cycle();
        // R1: child 2 climbs on parent 1
        send(2, 6'h2C);
        cycle(); cycle();
        chk(up_out_valid == 2'b10, "R1", "child2 climb port", up_out_valid, 2'b10);
        cycle();
        // R2: child 0 turns to child 2
        send(0, 6'h08);
        cycle(); cycle();
        chk(dn_out_valid == 4'b0100, "R2", "turn to child2", dn_out_valid, 4'b0100);
        cycle();
        // R3: parent 0 descends to child 3 whatever its upper bits
        send(4, 6'h3C);
        cycle(); cycle();
        chk(dn_out_valid == 4'b1000, "R3", "descend to child3", dn_out_valid, 4'b1000);
        cycle();
        // R4: child 1 addressed to itself is accepted and discarded
        send(1, 6'h04);
        cycle();
        chk(pend[1].size() == 0, "R4", "self flit accepted", pend[1].size(), 0);
        cycle();
        chk({up_out_valid, dn_out_valid} == 6'h00, "R4", "self flit not forwarded", {up_out_valid, dn_out_valid}, 0);
        chk(dn_in_ready[1] == 1'b1, "R4", "ready kept", dn_in_ready[1], 1);
        cycle();
        // R6: stalled parent 0 holds its flit
        orv[4] = 1'b0;
        send(1, 6'h20);
        cycle(); cycle();
        held = up_out_data[FW-1:0];
        repeat (3) cycle();
        chk(up_out_valid[0] == 1'b1, "R6", "stalled valid", up_out_valid[0], 1);
        chk(up_out_data[FW-1:0] == held, "R6", "stalled data", up_out_data[FW-1:0], held);
        orv[4] = 1'b1;
        repeat (2) cycle();
        chk(outstanding() == 0, "R6", "stalled flit delivered", outstanding(), 0);

        // R7 + R8: children 0 and 1 contend for parent 0
        u0_src.delete();
        repeat (3) begin send(0, 6'h10); send(1, 6'h10); end
        cycle(); cycle();
        chk(dn_in_ready[1] == 1'b0, "R8", "loser backpressured", dn_in_ready[1], 0);
        repeat (8) cycle();
        chk(u0_src.size() == 6, "R8", "all contenders delivered", u0_src.size(), 6);
        for (int i = 0; i < u0_src.size(); i++)
            chk(u0_src[i] == i % 2, "R7", "round-robin order", u0_src[i], i % 2);

        // R9: seeded random traffic with random output stalls
        for (int c = 0; c < 3000; c++) begin
            for (int p = 0; p < 6; p++) begin
                if (($urandom % 4) == 0 && pend[p].size() < 4) send(p, 6'($urandom));
                orv[p] = (($urandom % 4) != 0);
            end
            cycle();
        end
        for (int p = 0; p < 6; p++) orv[p] = 1'b1;
        for (int c = 0; c < 300 && outstanding() != 0; c++) cycle();
        chk(outstanding() == 0, "R9", "nothing lost", outstanding(), 0);
        chk({up_in_ready, dn_in_ready} == 6'h3F, "R8", "ready restored", {up_in_ready, dn_in_ready}, 6'h3F);

        $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
        $finish;
    end
endmodule